// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a 14-bit virtual address into a physical address by way of three segment register sets: one for code, one for heap and one for stack. The two upper address bits pick the set; the twelve lower bits are the offset inside the segment. Each set holds a base, a size, a growth direction flag and three permission bits (read, write, execute). A segment that grows upward adds the offset to its base. A segment that grows downward adds a negative offset (offset minus the 4 KB maximum) to its base. Every access is checked first against the segment size and then against the permission bits. A failed access returns a fault code and a zeroed physical address.

Requests come in on a valid/ready stream, and results leave on a second valid/ready stream one cycle after acceptance. A single output register sits between the two streams. A new request is accepted when that register is empty, or when its content is taken in the same cycle. While the consumer holds `rsp_ready` low, the response stays frozen and `req_ready` stays low. Once asserted, `req_valid` and its payload must stay put until accepted. Software loads the segment sets through a plain write port that has no handshake.

Top module: `seg_xlate_unit`

## Requirements
- R1: Address bits 13:12 select the segment: 00 selects code, 01 selects heap, and both 10 and 11 select stack. The offset is bits 11:0.
- R2: In an upward segment (direction flag 0), the access passes the bounds check only if offset < size, and the physical address is (base + offset) modulo 2^PA_W.
- R3: In a downward segment (direction flag 1), the access passes the bounds check only if (4096 - offset) <= size, and the physical address is (base + offset - 4096) modulo 2^PA_W.
- R4: Access type encoding is 00 read, 01 write, 10 fetch, and 11 is treated as read. Permission bits are bit 0 read, bit 1 write and bit 2 execute. An access that passes the bounds check but lacks its permission bit returns fault code 2'b10.
- R5: A bounds failure returns fault code 2'b01 and takes priority over a permission failure.
- R6: A successful access returns fault code 2'b00. Any fault forces the physical address output to zero.
- R7: After reset the response stream is empty, and every segment holds base 0, size 0, direction 0 and no permissions, so every access returns a bounds fault.
- R8: A request accepted at a clock edge appears on the response port after that edge, with `rsp_valid` high.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the response stays unchanged and `req_ready` is low. When `rsp_ready` rises, the pending request is accepted in the same cycle that the old response leaves.
- R10: A segment write and an accepted request in the same cycle: the request is translated with the segment values from before the write, and the write takes effect for later requests.
- R11: A write with selector 00, 01 or 10 loads code, heap or stack. A write with selector 11 changes no segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_vaddr | input | 14 | Virtual address |
| req_acc | input | 2 | Access type (00 read, 01 write, 10 fetch) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | PA_W | Physical address, zero on fault |
| rsp_fault | output | 2 | 00 none, 01 bounds, 10 protection |
| cfg_we | input | 1 | Segment write strobe |
| cfg_sel | input | 2 | Segment selector (00 code, 01 heap, 10 stack, 11 none) |
| cfg_base | input | PA_W | Base to load |
| cfg_size | input | 13 | Size in bytes to load, 0 to 4096 |
| cfg_down | input | 1 | Growth direction, 1 is downward |
| cfg_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |

## Verification
A segment write and a translation of the same segment can happen in the same cycle. The bench provokes this by driving a heap write and a heap request on one edge. It then judges the result by checking that the response was built from the old base and size, and that the next request uses the new values. Back-pressure can also coincide with a new request. The bench stalls `rsp_ready` while a second request waits, and judges that the first response stays frozen and that the second one arrives on the edge that drains the first.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  localparam int NSEG   = 3;
  localparam int PERM_N = 3;
  localparam int PRM_RD = 0;
  localparam int PRM_WR = 1;
  localparam int PRM_EX = 2;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_BOUNDS = 2'b01,
    FLT_PROT   = 2'b10
  } flt_e;

  typedef enum logic [1:0] {
    ACC_RD    = 2'b00,
    ACC_WR    = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_ALT   = 2'b11
  } acc_e;

  // segment index from the two selector bits: 1x folds onto stack
  function automatic logic [1:0] seg_index(input logic [1:0] sel);
    return sel[1] ? 2'd2 : {1'b0, sel[0]};
  endfunction

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_xlate_pkg::*;
#(
  parameter int PA_W   = 16,
  parameter int SIZE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [PA_W-1:0]   wr_base,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic              wr_down,
  input  logic [PERM_N-1:0] wr_perm,
  input  logic [1:0]        rd_idx,
  output logic [PA_W-1:0]   rd_base,
  output logic [SIZE_W-1:0] rd_size,
  output logic              rd_down,
  output logic [PERM_N-1:0] rd_perm
);

  logic [PA_W-1:0]   base_q [NSEG];
  logic [SIZE_W-1:0] size_q [NSEG];
  logic              down_q [NSEG];
  logic [PERM_N-1:0] perm_q [NSEG];

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    logic hit;
    assign hit = wr_en && (wr_sel == 2'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[i] <= '0;
        size_q[i] <= '0;
        down_q[i] <= 1'b0;
        perm_q[i] <= '0;
      end else if (hit) begin
        base_q[i] <= wr_base;
        size_q[i] <= wr_size;
        down_q[i] <= wr_down;
        perm_q[i] <= wr_perm;
      end
    end

    // R11: a write aimed elsewhere (including selector 11) leaves this set alone
    p_keep_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel != 2'(i)) |=> ($stable(base_q[i]) && $stable(size_q[i])
                                      && $stable(down_q[i]) && $stable(perm_q[i])));
  end

  always_comb begin
    rd_base = '0;
    rd_size = '0;
    rd_down = 1'b0;
    rd_perm = '0;
    for (int k = 0; k < NSEG; k++) begin
      if (rd_idx == 2'(k)) begin
        rd_base = base_q[k];
        rd_size = size_q[k];
        rd_down = down_q[k];
        rd_perm = perm_q[k];
      end
    end
  end

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int PA_W  = 16,
  parameter int OFF_W = 12
) (
  input  logic [OFF_W-1:0]  offset,
  input  logic [PA_W-1:0]   base,
  input  logic [OFF_W:0]    size,
  input  logic              down,
  input  logic [PERM_N-1:0] perm,
  input  logic [1:0]        acc,
  output logic [PA_W-1:0]   paddr,
  output logic [1:0]        fault
);

  localparam int SPAN = 1 << OFF_W;

  logic [OFF_W:0]  off_ext;
  logic [OFF_W:0]  neg_mag;
  logic            in_bounds;
  logic            allowed;
  logic [PA_W-1:0] sum_up;
  logic [PA_W-1:0] sum_down;
  flt_e            flt;

  assign off_ext = {1'b0, offset};
  assign neg_mag = (OFF_W+1)'(SPAN) - off_ext;
  assign sum_up   = base + PA_W'(offset);
  assign sum_down = base + PA_W'(offset) - PA_W'(SPAN);

  always_comb begin
    if (down) in_bounds = (neg_mag <= size);
    else      in_bounds = (off_ext < size);
  end

  always_comb begin
    unique case (acc_e'(acc))
      ACC_WR:    allowed = perm[PRM_WR];
      ACC_FETCH: allowed = perm[PRM_EX];
      default:   allowed = perm[PRM_RD];
    endcase
  end

  always_comb begin
    if (!in_bounds)    flt = FLT_BOUNDS;
    else if (!allowed) flt = FLT_PROT;
    else               flt = FLT_NONE;
  end

  assign fault = flt;
  assign paddr = (flt != FLT_NONE) ? '0 : (down ? sum_down : sum_up);

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int PA_W = 16,
  parameter int VA_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [1:0]      req_acc,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [PA_W-1:0] rsp_paddr,
  output logic [1:0]      rsp_fault,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [PA_W-1:0] cfg_base,
  input  logic [VA_W-2:0] cfg_size,
  input  logic            cfg_down,
  input  logic [2:0]      cfg_perm
);

  localparam int OFF_W  = VA_W - 2;
  localparam int SIZE_W = OFF_W + 1;

  logic [1:0]        seg_idx;
  logic [PA_W-1:0]   s_base;
  logic [SIZE_W-1:0] s_size;
  logic              s_down;
  logic [PERM_N-1:0] s_perm;
  logic [PA_W-1:0]   x_paddr;
  logic [1:0]        x_fault;
  logic              take;

  assign seg_idx = seg_index(req_vaddr[VA_W-1:VA_W-2]);

  seg_regfile #(.PA_W(PA_W), .SIZE_W(SIZE_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_sel  (cfg_sel),
    .wr_base (cfg_base),
    .wr_size (cfg_size),
    .wr_down (cfg_down),
    .wr_perm (cfg_perm),
    .rd_idx  (seg_idx),
    .rd_base (s_base),
    .rd_size (s_size),
    .rd_down (s_down),
    .rd_perm (s_perm)
  );

  seg_check #(.PA_W(PA_W), .OFF_W(OFF_W)) u_check (
    .offset (req_vaddr[OFF_W-1:0]),
    .base   (s_base),
    .size   (s_size),
    .down   (s_down),
    .perm   (s_perm),
    .acc    (req_acc),
    .paddr  (x_paddr),
    .fault  (x_fault)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= FLT_NONE;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_paddr <= x_paddr;
        rsp_fault <= x_fault;
      end
    end
  end

  // R8: accepted request shows up on the response port next cycle
  p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rsp_valid);

  // R9: stalled response is frozen
  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  // R6: faulted responses carry a zero address
  p_zero_on_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_paddr == '0));

  // R4: fault code 11 is never produced
  p_legal_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault != 2'b11));

endmodule

// File: tb/seg_xlate_unit_test.sv
module seg_xlate_unit_test;

  localparam int PA_W = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [13:0]     req_vaddr = '0;
  logic [1:0]      req_acc = '0;
  logic            rsp_valid;
  logic            rsp_ready = 1'b1;
  logic [PA_W-1:0] rsp_paddr;
  logic [1:0]      rsp_fault;
  logic            cfg_we = 1'b0;
  logic [1:0]      cfg_sel = '0;
  logic [PA_W-1:0] cfg_base = '0;
  logic [12:0]     cfg_size = '0;
  logic            cfg_down = 1'b0;
  logic [2:0]      cfg_perm = '0;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // bench model of the segment sets
  logic [PA_W-1:0] m_base [3];
  logic [12:0]     m_size [3];
  logic            m_down [3];
  logic [2:0]      m_perm [3];

  always #10 clk = ~clk;

  seg_xlate_unit #(.PA_W(PA_W), .VA_W(14)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_base(cfg_base),
    .cfg_size(cfg_size), .cfg_down(cfg_down), .cfg_perm(cfg_perm)
  );

  function automatic int seg_of(logic [13:0] va);
    return va[13] ? 2 : int'(va[12]);
  endfunction

  // expected {fault, paddr} from the requirements
  function automatic logic [PA_W+1:0] model(logic [13:0] va, logic [1:0] acc);
    int s = seg_of(va);
    int off = int'(va[11:0]);
    bit ok_b, ok_p;
    int pa;
    int pbit;
    if (m_down[s]) begin
      ok_b = (4096 - off) <= int'(m_size[s]);
      pa = int'(m_base[s]) + off - 4096;
    end else begin
      ok_b = off < int'(m_size[s]);
      pa = int'(m_base[s]) + off;
    end
    pbit = (acc == 2'b01) ? 1 : (acc == 2'b10) ? 2 : 0;
    ok_p = m_perm[s][pbit];
    if (!ok_b) return {2'b01, {PA_W{1'b0}}};
    if (!ok_p) return {2'b10, {PA_W{1'b0}}};
    return {2'b00, PA_W'(pa)};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic seg_write(logic [1:0] sel, logic [PA_W-1:0] b, logic [12:0] sz,
                           logic dn, logic [2:0] pm);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_base = b; cfg_size = sz;
    cfg_down = dn; cfg_perm = pm;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel != 2'b11) begin
      m_base[sel] = b; m_size[sel] = sz; m_down[sel] = dn; m_perm[sel] = pm;
    end
  endtask

  // one request with the consumer ready; response sampled at the next negedge
  task automatic xlate(string tag, logic [13:0] va, logic [1:0] acc);
    logic [PA_W+1:0] e;
    e = model(va, acc);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " fault"}, 32'(rsp_fault), 32'(e[PA_W+1:PA_W]));
    check({tag, " paddr"}, 32'(rsp_paddr), 32'(e[PA_W-1:0]));
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [PA_W+1:0] ea;
    logic [PA_W+1:0] eb;
    void'($urandom(32'd4242));
    for (int i = 0; i < 3; i++) begin
      m_base[i] = '0; m_size[i] = '0; m_down[i] = 1'b0; m_perm[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    check("R7 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    check("R7 req_ready after reset", 32'(req_ready), 32'd1);
    xlate("R7 unprogrammed heap", 14'h1010, 2'b00);
    xlate("R7 unprogrammed stack", 14'h3C00, 2'b00);

    // program: code up, heap up, stack down
    seg_write(2'b00, 16'h8000, 13'd2048, 1'b0, 3'b101);
    seg_write(2'b01, 16'h9000, 13'd1000, 1'b0, 3'b011);
    seg_write(2'b10, 16'd28672, 13'd1024, 1'b1, 3'b011);

    // R1/R2 upward segments, edge of bound
    xlate("R2 heap offset 104", 14'd4200, 2'b00);
    xlate("R2 heap last byte", 14'h1000 + 14'd999, 2'b01);
    xlate("R2 heap at bound", 14'h1000 + 14'd1000, 2'b00);
    xlate("R1 code select", 14'h0123, 2'b10);
    // R3 downward stack, the 3 KB example and its neighbours
    xlate("R3 stack 3KB", 14'h3C00, 2'b00);
    xlate("R1 stack via 10", 14'h2C00, 2'b01);
    xlate("R3 stack one past", 14'h3BFF, 2'b00);
    seg_write(2'b10, 16'h5000, 13'd4096, 1'b1, 3'b001);
    xlate("R3 stack full span offset 0", 14'h3000, 2'b00);
    // R4 protection
    xlate("R4 code write", 14'h0010, 2'b01);
    xlate("R4 code fetch ok", 14'h0010, 2'b10);
    xlate("R4 heap fetch", 14'h1004, 2'b10);
    xlate("R4 alt type as read", 14'h1004, 2'b11);
    // R5 bounds before protection
    xlate("R5 code write out of bounds", 14'h0900, 2'b01);

    // R11 selector 11 writes nothing
    seg_write(2'b11, 16'h1234, 13'd4096, 1'b0, 3'b111);
    xlate("R11 code unchanged", 14'h0900, 2'b00);
    xlate("R11 heap unchanged", 14'h1004, 2'b01);

    // R10 same-cycle write and request on heap
    ea = model(14'h1008, 2'b00);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'b01; cfg_base = 16'hA000; cfg_size = 13'd16;
    cfg_down = 1'b0; cfg_perm = 3'b001;
    req_valid = 1'b1; req_vaddr = 14'h1008; req_acc = 2'b00;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    m_base[1] = 16'hA000; m_size[1] = 13'd16; m_down[1] = 1'b0; m_perm[1] = 3'b001;
    check("R10 old values used", 32'(rsp_paddr), 32'(ea[PA_W-1:0]));
    xlate("R10 new values next", 14'h1008, 2'b00);

    // R8/R9 back-pressure
    ea = model(14'h0020, 2'b00);
    eb = model(14'h1002, 2'b00);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_vaddr = 14'h0020; req_acc = 2'b00;
    @(negedge clk);
    check("R8 first accepted", 32'(rsp_valid), 32'd1);
    req_vaddr = 14'h1002;
    for (int i = 0; i < 3; i++) begin
      check("R9 ready low while stalled", 32'(req_ready), 32'd0);
      check("R9 held paddr", 32'(rsp_paddr), 32'(ea[PA_W-1:0]));
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 second after drain valid", 32'(rsp_valid), 32'd1);
    check("R9 second after drain paddr", 32'(rsp_paddr), 32'(eb[PA_W-1:0]));
    @(negedge clk);
    check("R8 empty after drain", 32'(rsp_valid), 32'd0);

    // random phase
    for (int n = 0; n < 400; n++) begin
      logic [13:0] va;
      if (n % 40 == 0) begin
        for (int s = 0; s < 3; s++)
          seg_write(2'(s), PA_W'($urandom), 13'($urandom_range(0, 4096)),
                    1'($urandom), 3'($urandom));
      end
      va = 14'($urandom);
      xlate("R2/R3/R4 random", va, 2'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule